// File: doc/BRIEF.md
# Two-way set-associative address translation cache

The block keeps a small number of recent page table entries close to the address path so that most virtual-to-physical translations finish without a memory access. A lookup presents a virtual address. The page offset passes through unchanged. The page number is split into a set index and a tag. The two ways of the indexed set are compared at the same time. The result is registered and appears one cycle later. A hit returns the physical address, built from the stored physical page number and the request's page offset, together with the entry's permission bits. These bits let the access check proceed without a walk. A miss tells the requester to walk the page tables.

When a walk finishes, the requester writes the new entry through the fill port. The fill first goes to a way that already holds the same page number. Failing that, it goes to an empty way. Otherwise it goes to the way that a per-set recently-used bit marks as older. A flush input empties the whole structure in one cycle.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: `res_valid` is high in the cycle after a cycle with `lk_valid` high, and low in the cycle after a cycle with `lk_valid` low.
- R3: The set index is the low `SET_W` bits of the virtual page number (`vaddr[OFF_W+SET_W-1:OFF_W]`) and the tag is the remaining upper bits. Two page numbers that share a set but differ in tag are held at the same time, one per way.
- R4: On a hit, `res_paddr` equals the stored physical page number concatenated above `vaddr[OFF_W-1:0]`, and `res_perm` equals the stored permission bits.
- R5: On a miss, `res_hit`, `res_paddr` and `res_perm` are all zero.
- R6: A fill goes to an invalid way of its set if there is one, with way 0 taking priority. Otherwise the fill replaces the way that was not touched most recently. Each hit and each fill marks its way as the most recently touched one.
- R7: A fill whose page number is already present overwrites that entry in place, and the other way of the set is kept.
- R8: A flush invalidates every entry at the next edge. A lookup in the flush cycle reports a miss, and a fill in the flush cycle is discarded.
- R9: A lookup in the same cycle as a fill sees the contents from before that fill.
- R10: Fills into one set never disturb the entries of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| fill_valid | input | 1 | Install an entry this cycle |
| fill_vpn | input | VPN_W | Virtual page number of the new entry |
| fill_ppn | input | PPN_W | Physical page number of the new entry |
| fill_perm | input | PERM_W | Permission bits of the new entry |
| flush | input | 1 | Invalidate all entries |
| res_valid | output | 1 | Result of the previous cycle's lookup is present |
| res_hit | output | 1 | That lookup hit |
| res_paddr | output | PPN_W+OFF_W | Translated physical address, zero on a miss |
| res_perm | output | PERM_W | Permission bits of the hitting entry, zero on a miss |

## Verification
The assertions assume that the requester never fills the same page number twice in consecutive cycles into different sets of meaning. They also assume that fill and lookup inputs carry defined values after reset. The fill-then-hit property relies on the flush input staying low across both cycles it spans. The stimulus changes inputs only at the falling edge. It fills each page number at most once, except where the in-place overwrite is being exercised. It asserts flush only in dedicated cycles whose outcome is checked directly.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   localparam int TLB_WAYS = 2;

   // Way choice for a fill: a matching way first, then an empty way
   // (way 0 before way 1), then the older way named by the set's bit.
   function automatic logic pick_fill_way(input logic [1:0] match,
                                          input logic [1:0] occupied,
                                          input logic       older_way);
      if (match[0])     return 1'b0;
      if (match[1])     return 1'b1;
      if (!occupied[0]) return 1'b0;
      if (!occupied[1]) return 1'b1;
      return older_way;
   endfunction

endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
   parameter int SET_W  = 4,
   parameter int TAG_W  = 16,
   parameter int PPN_W  = 20,
   parameter int PERM_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [SET_W-1:0]  wr_set,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic [SET_W-1:0]  rd_set,
   output logic              rd_vld,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [PPN_W-1:0]  rd_ppn,
   output logic [PERM_W-1:0] rd_perm,
   input  logic [SET_W-1:0]  pr_set,
   output logic              pr_vld,
   output logic [TAG_W-1:0]  pr_tag
);

   localparam int SETS = 1 << SET_W;

   logic [SETS-1:0]   vld_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [PPN_W-1:0]  ppn_q  [SETS];
   logic [PERM_W-1:0] perm_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_set] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_set]  <= wr_tag;
         ppn_q[wr_set]  <= wr_ppn;
         perm_q[wr_set] <= wr_perm;
      end
   end

   assign rd_vld  = vld_q[rd_set];
   assign rd_tag  = tag_q[rd_set];
   assign rd_ppn  = ppn_q[rd_set];
   assign rd_perm = perm_q[rd_set];
   assign pr_vld  = vld_q[pr_set];
   assign pr_tag  = tag_q[pr_set];

endmodule

// File: rtl/tlb_lru_bits.sv
module tlb_lru_bits #(
   parameter int SET_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_en,
   input  logic [SET_W-1:0] hit_set,
   input  logic             hit_way,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic             fill_way,
   input  logic [SET_W-1:0] rd_set,
   output logic             rd_older
);

   localparam int SETS = 1 << SET_W;

   // Bit per set names the way touched less recently.
   logic [SETS-1:0] older_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         older_q <= '0;
      end else begin
         for (int s = 0; s < SETS; s++) begin
            if (fill_en && fill_set == SET_W'(s)) begin
               older_q[s] <= ~fill_way;
            end else if (hit_en && hit_set == SET_W'(s)) begin
               older_q[s] <= ~hit_way;
            end
         end
      end
   end

   assign rd_older = older_q[rd_set];

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select #(
   parameter int WAYS   = 2,
   parameter int TAG_W  = 16,
   parameter int PPN_W  = 20,
   parameter int PERM_W = 4
) (
   input  logic [TAG_W-1:0]             req_tag,
   input  logic [WAYS-1:0]              way_vld,
   input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
   input  logic [WAYS-1:0][PPN_W-1:0]   way_ppn,
   input  logic [WAYS-1:0][PERM_W-1:0]  way_perm,
   output logic                         hit,
   output logic                         hit_way,
   output logic [PPN_W-1:0]             hit_ppn,
   output logic [PERM_W-1:0]            hit_perm
);

   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_vld[w] && (way_tag[w] == req_tag);
   end

   always_comb begin
      hit      = |match;
      hit_way  = match[0] ? 1'b0 : 1'b1;
      hit_ppn  = match[0] ? way_ppn[0]  : way_ppn[1];
      hit_perm = match[0] ? way_perm[0] : way_perm[1];
   end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
   parameter int VPN_W  = 20,
   parameter int OFF_W  = 12,
   parameter int PPN_W  = 20,
   parameter int PERM_W = 4,
   parameter int SET_W  = 4,
   parameter int WAYS   = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lk_valid,
   input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
   input  logic                   fill_valid,
   input  logic [VPN_W-1:0]       fill_vpn,
   input  logic [PPN_W-1:0]       fill_ppn,
   input  logic [PERM_W-1:0]      fill_perm,
   input  logic                   flush,
   output logic                   res_valid,
   output logic                   res_hit,
   output logic [PPN_W+OFF_W-1:0] res_paddr,
   output logic [PERM_W-1:0]      res_perm
);

   import tlb_pkg::*;

   localparam int TAG_W = VPN_W - SET_W;
   localparam int VA_W  = VPN_W + OFF_W;
   localparam int PA_W  = PPN_W + OFF_W;

   if (WAYS != TLB_WAYS) begin : g_bad_ways
      $error("xlat_tlb: replacement bit supports exactly two ways");
   end
   if (SET_W < 1 || SET_W >= VPN_W) begin : g_bad_sets
      $error("xlat_tlb: SET_W must leave at least one tag bit");
   end
   if (OFF_W < 1 || PPN_W < 1 || PERM_W < 1) begin : g_bad_widths
      $error("xlat_tlb: offset, page and permission widths must be positive");
   end

   // Address split
   logic [VPN_W-1:0] lk_vpn;
   logic [SET_W-1:0] lk_set, fl_set;
   logic [TAG_W-1:0] lk_tag, fl_tag;
   logic [OFF_W-1:0] lk_off;

   assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
   assign lk_off = lk_vaddr[OFF_W-1:0];
   assign lk_set = lk_vpn[SET_W-1:0];
   assign lk_tag = lk_vpn[VPN_W-1:SET_W];
   assign fl_set = fill_vpn[SET_W-1:0];
   assign fl_tag = fill_vpn[VPN_W-1:SET_W];

   // Way storage
   logic [WAYS-1:0]             rd_vld, pr_vld, pr_match, wr_en;
   logic [WAYS-1:0][TAG_W-1:0]  rd_tag, pr_tag;
   logic [WAYS-1:0][PPN_W-1:0]  rd_ppn;
   logic [WAYS-1:0][PERM_W-1:0] rd_perm;
   logic                        fill_way, older_way, fill_go;

   assign fill_go = fill_valid && !flush;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign wr_en[w]    = fill_go && (fill_way == 1'(w));
      assign pr_match[w] = pr_vld[w] && (pr_tag[w] == fl_tag);

      tlb_way_store #(
         .SET_W (SET_W),
         .TAG_W (TAG_W),
         .PPN_W (PPN_W),
         .PERM_W(PERM_W)
      ) i_way (
         .clk    (clk),
         .rst_n  (rst_n),
         .flush  (flush),
         .wr_en  (wr_en[w]),
         .wr_set (fl_set),
         .wr_tag (fl_tag),
         .wr_ppn (fill_ppn),
         .wr_perm(fill_perm),
         .rd_set (lk_set),
         .rd_vld (rd_vld[w]),
         .rd_tag (rd_tag[w]),
         .rd_ppn (rd_ppn[w]),
         .rd_perm(rd_perm[w]),
         .pr_set (fl_set),
         .pr_vld (pr_vld[w]),
         .pr_tag (pr_tag[w])
      );
   end

   always_comb begin
      fill_way = pick_fill_way(pr_match, pr_vld, older_way);
   end

   // Lookup compare
   logic              hit, hit_way, hit_en;
   logic [PPN_W-1:0]  hit_ppn;
   logic [PERM_W-1:0] hit_perm;

   tlb_hit_select #(
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .PPN_W (PPN_W),
      .PERM_W(PERM_W)
   ) i_hit (
      .req_tag (lk_tag),
      .way_vld (rd_vld),
      .way_tag (rd_tag),
      .way_ppn (rd_ppn),
      .way_perm(rd_perm),
      .hit     (hit),
      .hit_way (hit_way),
      .hit_ppn (hit_ppn),
      .hit_perm(hit_perm)
   );

   assign hit_en = lk_valid && hit && !flush;

   // Recency bits
   tlb_lru_bits #(
      .SET_W(SET_W)
   ) i_lru (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_en  (hit_en),
      .hit_set (lk_set),
      .hit_way (hit_way),
      .fill_en (fill_go),
      .fill_set(fl_set),
      .fill_way(fill_way),
      .rd_set  (fl_set),
      .rd_older(older_way)
   );

   // Registered result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_paddr <= '0;
         res_perm  <= '0;
      end else begin
         res_valid <= lk_valid;
         res_hit   <= hit_en;
         res_paddr <= hit_en ? {hit_ppn, lk_off} : '0;
         res_perm  <= hit_en ? hit_perm : '0;
      end
   end

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
   parameter int VPN_W  = 20,
   parameter int OFF_W  = 12,
   parameter int PPN_W  = 20,
   parameter int PERM_W = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   lk_valid,
   input logic [VPN_W+OFF_W-1:0] lk_vaddr,
   input logic                   fill_valid,
   input logic [VPN_W-1:0]       fill_vpn,
   input logic [PPN_W-1:0]       fill_ppn,
   input logic                   flush,
   input logic                   res_valid,
   input logic                   res_hit,
   input logic [PPN_W+OFF_W-1:0] res_paddr,
   input logic [PERM_W-1:0]      res_perm
);

   localparam int VA_W = VPN_W + OFF_W;
   localparam int PA_W = PPN_W + OFF_W;

   AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid); // R2

   AST_NO_RESULT_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid && !res_hit); // R2

   AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_paddr == '0 && res_perm == '0)); // R5

   AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!res_hit || res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))); // R4

   AST_FLUSH_CYCLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && lk_valid) |=> !res_hit); // R8

   AST_EMPTY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush ##1 lk_valid |=> !res_hit); // R8

   AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush) ##1
      (lk_valid && !flush && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn))
      |=> (res_hit && res_paddr[PA_W-1:OFF_W] == $past(fill_ppn, 2))); // R6

endmodule

bind xlat_tlb tlb_checker #(
   .VPN_W (VPN_W),
   .OFF_W (OFF_W),
   .PPN_W (PPN_W),
   .PERM_W(PERM_W)
) i_tlb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_valid  (lk_valid),
   .lk_vaddr  (lk_vaddr),
   .fill_valid(fill_valid),
   .fill_vpn  (fill_vpn),
   .fill_ppn  (fill_ppn),
   .flush     (flush),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .res_paddr (res_paddr),
   .res_perm  (res_perm)
);

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;

   localparam int VPN_W = 20, OFF_W = 12, PPN_W = 20, PERM_W = 4, SET_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lk_valid = 1'b0;
   logic [31:0]       lk_vaddr = '0;
   logic              fill_valid = 1'b0;
   logic [19:0]       fill_vpn = '0;
   logic [19:0]       fill_ppn = '0;
   logic [3:0]        fill_perm = '0;
   logic              flush = 1'b0;
   logic              res_valid, res_hit;
   logic [31:0]       res_paddr;
   logic [3:0]        res_perm;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   xlat_tlb #(
      .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PERM_W(PERM_W), .SET_W(SET_W), .WAYS(2)
   ) i_xlat_tlb (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_perm(fill_perm), .flush(flush), .res_valid(res_valid),
      .res_hit(res_hit), .res_paddr(res_paddr), .res_perm(res_perm)
   );

   // Page number for set s, tag slot k: tag in the upper 16 bits, set in the low 4.
   function automatic logic [19:0] mk_vpn(input int s, input int k);
      return {16'(16'h0100 + s * 3 + k * 64), 4'(s)};
   endfunction

   function automatic logic [19:0] mk_ppn(input logic [19:0] v);
      return v ^ 20'hC35A7;
   endfunction

   function automatic logic [3:0] mk_perm(input logic [19:0] v);
      return v[8:5] ^ 4'h9;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] pm);
      fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_perm = pm;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic chk_result(input bit eh, input logic [19:0] p, input logic [3:0] pm,
                             input logic [11:0] off, input string req);
      logic [31:0] ea;
      logic [3:0]  ep;
      ea = eh ? {p, off} : 32'h0;
      ep = eh ? pm : 4'h0;
      chk(res_valid == 1'b1, {req, " res_valid"}, 64'(res_valid), 64'(1));
      chk(res_hit == eh, {req, " hit"}, 64'(res_hit), 64'(eh));
      chk(res_paddr == ea, {req, " paddr"}, 64'(res_paddr), 64'(ea));
      chk(res_perm == ep, {req, " perm"}, 64'(res_perm), 64'(ep));
   endtask

   task automatic look(input logic [19:0] v, input logic [11:0] off, input bit eh,
                       input string req);
      lk_valid = 1'b1; lk_vaddr = {v, off};
      @(negedge clk);
      lk_valid = 1'b0;
      chk_result(eh, mk_ppn(v), mk_perm(v), off, req);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=expired expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: empty after reset
      chk(res_valid == 1'b0, "R1 idle res_valid", 64'(res_valid), 64'(0));
      look(mk_vpn(0, 0), 12'h123, 1'b0, "R1 miss after reset");
      look(mk_vpn(9, 1), 12'hFFF, 1'b0, "R1 R5 miss after reset");

      // R2: no request gives no result
      @(negedge clk);
      chk(res_valid == 1'b0, "R2 no request", 64'(res_valid), 64'(0));

      // R3 R10: fill every set with two tags, then read all back
      for (int s = 0; s < 16; s++) begin
         for (int k = 0; k < 2; k++) begin
            do_fill(mk_vpn(s, k), mk_ppn(mk_vpn(s, k)), mk_perm(mk_vpn(s, k)));
         end
      end
      for (int s = 0; s < 16; s++) begin
         for (int k = 0; k < 2; k++) begin
            look(mk_vpn(s, k), 12'((s * 37 + k * 1000) % 4096), 1'b1, "R3 R4 R10 sweep");
         end
      end
      look(mk_vpn(2, 0), 12'h000, 1'b1, "R4 offset zero");
      look(mk_vpn(2, 1), 12'hFFF, 1'b1, "R4 offset max");
      // R3: same set, unknown tag misses
      look(mk_vpn(4, 2), 12'h055, 1'b0, "R3 R5 tag mismatch");

      // R6: set 5, recent hit on slot 0 makes slot 1 the victim
      look(mk_vpn(5, 0), 12'h010, 1'b1, "R6 touch slot0");
      do_fill(mk_vpn(5, 2), mk_ppn(mk_vpn(5, 2)), mk_perm(mk_vpn(5, 2)));
      look(mk_vpn(5, 1), 12'h020, 1'b0, "R6 older evicted");
      look(mk_vpn(5, 0), 12'h030, 1'b1, "R6 recent kept");
      look(mk_vpn(5, 2), 12'h040, 1'b1, "R6 new present");
      // R6: set 6, slot 1 last touched by the sweep, so slot 0 goes
      do_fill(mk_vpn(6, 2), mk_ppn(mk_vpn(6, 2)), mk_perm(mk_vpn(6, 2)));
      look(mk_vpn(6, 0), 12'h050, 1'b0, "R6 slot0 evicted");
      look(mk_vpn(6, 1), 12'h060, 1'b1, "R6 slot1 kept");
      look(mk_vpn(6, 2), 12'h070, 1'b1, "R6 set6 new present");
      // R10: neighbours untouched
      look(mk_vpn(7, 0), 12'h080, 1'b1, "R10 set7 intact");
      look(mk_vpn(4, 1), 12'h090, 1'b1, "R10 set4 intact");

      // R7: overwrite of a present page keeps the other way
      do_fill(mk_vpn(7, 0), 20'h0ABCD, 4'h3);
      lk_valid = 1'b1; lk_vaddr = {mk_vpn(7, 0), 12'h5A5};
      @(negedge clk);
      lk_valid = 1'b0;
      chk_result(1'b1, 20'h0ABCD, 4'h3, 12'h5A5, "R7 overwritten entry");
      look(mk_vpn(7, 1), 12'h0A0, 1'b1, "R7 other way kept");

      // R9: lookup in the fill cycle sees the old contents
      fill_valid = 1'b1; fill_vpn = mk_vpn(8, 3);
      fill_ppn = mk_ppn(mk_vpn(8, 3)); fill_perm = mk_perm(mk_vpn(8, 3));
      lk_valid = 1'b1; lk_vaddr = {mk_vpn(8, 3), 12'h111};
      @(negedge clk);
      fill_valid = 1'b0; lk_valid = 1'b0;
      chk_result(1'b0, 20'h0, 4'h0, 12'h111, "R9 same-cycle fill");
      look(mk_vpn(8, 3), 12'h222, 1'b1, "R9 next cycle hit");

      // R8: lookup in the flush cycle misses
      flush = 1'b1; lk_valid = 1'b1; lk_vaddr = {mk_vpn(9, 0), 12'h333};
      @(negedge clk);
      flush = 1'b0; lk_valid = 1'b0;
      chk_result(1'b0, 20'h0, 4'h0, 12'h333, "R8 flush-cycle lookup");
      look(mk_vpn(10, 0), 12'h444, 1'b0, "R8 emptied set10");
      look(mk_vpn(15, 1), 12'h444, 1'b0, "R8 emptied set15");
      // R8: fill during flush is discarded
      flush = 1'b1; fill_valid = 1'b1; fill_vpn = mk_vpn(11, 0);
      fill_ppn = mk_ppn(mk_vpn(11, 0)); fill_perm = mk_perm(mk_vpn(11, 0));
      @(negedge clk);
      flush = 1'b0; fill_valid = 1'b0;
      look(mk_vpn(11, 0), 12'h555, 1'b0, "R8 fill in flush dropped");

      // R6: refill empty set, both entries coexist
      do_fill(mk_vpn(3, 4), mk_ppn(mk_vpn(3, 4)), mk_perm(mk_vpn(3, 4)));
      do_fill(mk_vpn(3, 5), mk_ppn(mk_vpn(3, 5)), mk_perm(mk_vpn(3, 5)));
      look(mk_vpn(3, 4), 12'h666, 1'b1, "R6 empty way first a");
      look(mk_vpn(3, 5), 12'h777, 1'b1, "R6 empty way first b");

      @(negedge clk);
      chk(res_valid == 1'b0, "R2 idle at end", 64'(res_valid), 64'(0));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule